// File: doc/BRIEF.md
# CDR Lock Supervisor

This block watches a bang-bang clock and data recovery loop and decides whether the loop is locked. On every detected rising data transition it receives a strobe together with the level of a quarter-UI-delayed copy of the recovered clock. The fraction of those samples that come back high is smoothed by a first-order recursive filter. When the loop tracks the data, that fraction sits near one. When it does not, the fraction sits near one half. The filtered level is compared against a two-thirds threshold that has a hysteresis band, and the result is a phase-lock flag. The filtered level is also brought out as a jitter indicator, because it falls as more data edges land outside the quadrature window.

The loop integrator reports saturation at either rail, and saturation means no data is arriving. The lock output is high only when phase lock holds and neither rail is reached. While phase lock is absent, the block requests a frequency sweep of the integrator and reverses the sweep each time a rail is hit. The sweep request drops once phase lock appears. The retimed data bit reaches the output through a register that freezes while the lock output is low. A bypass selector routes the raw input bit straight to the output, and in that mode freezing has no effect.

Top module: `cdr_lock_guard`

## Requirements
- R1: While reset is high and in the cycle after it is released: lock_o=0, sweep_en_o=1, sweep_up_o=1 (1 means upward), jitter_level_o=0, and with reclock_en_i=1 data_o=0.
- R2: At each clock edge with edge_stb_i=1, the level L (ACC_W-bit fraction, full scale 2^ACC_W) becomes L+((2^ACC_W-L)>>FILT_SHIFT) if quad_smp_i=1, or L-(L>>FILT_SHIFT) if quad_smp_i=0. Without a strobe, L is unchanged. jitter_level_o shows L after the edge.
- R3: Phase lock sets at the edge after the level is strictly greater than TH_ON (default 43253, that is 0.66×2^16).
- R4: Phase lock clears at the edge after the level is strictly below TH_ON-HYST (default 41205). Between the two thresholds it holds.
- R5: lock_o is combinationally phase lock AND NOT int_sat_hi_i AND NOT int_sat_lo_i.
- R6: sweep_en_o is 1 exactly when phase lock is 0.
- R7: While sweeping, an edge with int_sat_hi_i=1 sets sweep_up_o to 0. Otherwise, an edge with int_sat_lo_i=1 sets it to 1. While phase lock is 1, the direction holds.
- R8: With reclock_en_i=1 and lock_o=1 at an edge, data_o shows rt_data_i from that edge after the edge.
- R9: With reclock_en_i=1, an edge at which lock_o=0 leaves data_o unchanged (mute holds the last value).
- R10: With reclock_en_i=0, data_o equals raw_data_i in the same cycle, whatever the lock state. Phase lock and lock_o keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| edge_stb_i | input | 1 | Rising data transition detected this cycle |
| quad_smp_i | input | 1 | Quadrature clock level sampled at that transition |
| int_sat_hi_i | input | 1 | Integrator at upper rail |
| int_sat_lo_i | input | 1 | Integrator at lower rail |
| rt_data_i | input | 1 | Retimed data bit |
| raw_data_i | input | 1 | Unretimed data bit |
| reclock_en_i | input | 1 | 1 selects the retimed/mute path, 0 selects bypass |
| lock_o | output | 1 | Loop locked with data present |
| sweep_en_o | output | 1 | Frequency sweep requested |
| sweep_up_o | output | 1 | Sweep direction, 1 = up |
| jitter_level_o | output | ACC_W | Filtered quadrature-high fraction |
| data_o | output | 1 | Output data bit |

## Verification
The filtered level is due right after the strobed edge. Phase lock, and so sweep_en_o, follows one edge later because it is registered from the registered level. The sweep direction and the retimed data bit are due right after the edge that captures them. lock_o and the bypass path respond in the same cycle. The bench drives inputs just after the falling edge, checks one time unit later against a cycle model built from these latencies, and then advances the model at the rising edge. Each comparison is therefore tied to the register count on its path.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} sweep_dir_e;
   localparam int unsigned DEF_ACC_W   = 16;
   localparam int unsigned DEF_SHIFT   = 6;
   // two thirds of full scale expressed as 0.66 * 2^16
   localparam int unsigned DEF_TH_ON   = (66 * (1 << DEF_ACC_W)) / 100;
   localparam int unsigned DEF_HYST    = 2048;
endpackage

// File: rtl/qfrac_filter.sv
module qfrac_filter #(
   parameter int unsigned ACC_W = 16,
   parameter int unsigned SHIFT = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             stb_i,
   input  logic             smp_i,
   output logic [ACC_W-1:0] level_o
);
   localparam logic [ACC_W:0] FULL = {1'b1, {ACC_W{1'b0}}};

   logic [ACC_W-1:0] lvl_q;
   logic [ACC_W:0]   gap;
   logic [ACC_W:0]   rise;
   logic [ACC_W-1:0] fall;
   logic [ACC_W-1:0] lvl_d;

   always_comb begin
      gap  = FULL - {1'b0, lvl_q};
      rise = gap >> SHIFT;
      fall = lvl_q >> SHIFT;
      if (smp_i) lvl_d = lvl_q + rise[ACC_W-1:0];
      else       lvl_d = lvl_q - fall;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)      lvl_q <= '0;
      else if (stb_i) lvl_q <= lvl_d;
   end

   assign level_o = lvl_q;
endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis #(
   parameter int unsigned ACC_W  = 16,
   parameter int unsigned TH_ON  = 43253,
   parameter int unsigned TH_OFF = 41205
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [ACC_W-1:0] level_i,
   output logic             plock_o
);
   localparam logic [ACC_W-1:0] ON_V  = ACC_W'(TH_ON);
   localparam logic [ACC_W-1:0] OFF_V = ACC_W'(TH_OFF);

   logic pl_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)                        pl_q <= 1'b0;
      else if (!pl_q && level_i > ON_V) pl_q <= 1'b1;
      else if (pl_q && level_i < OFF_V) pl_q <= 1'b0;
   end

   assign plock_o = pl_q;
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
   import cdr_lock_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic plock_i,
   input  logic sat_hi_i,
   input  logic sat_lo_i,
   output logic sweep_en_o,
   output logic sweep_up_o
);
   sweep_dir_e dir_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)         dir_q <= DIR_UP;
      else if (!plock_i) begin
         if (sat_hi_i)      dir_q <= DIR_DOWN;
         else if (sat_lo_i) dir_q <= DIR_UP;
      end
   end

   assign sweep_en_o = !plock_i;
   assign sweep_up_o = (dir_q == DIR_UP);
endmodule

// File: rtl/out_gate.sv
module out_gate (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lock_i,
   input  logic rt_i,
   input  logic raw_i,
   input  logic reclock_en_i,
   output logic data_o
);
   logic held_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       held_q <= 1'b0;
      else if (lock_i) held_q <= rt_i;
   end

   assign data_o = reclock_en_i ? held_q : raw_i;
endmodule

// File: rtl/cdr_lock_guard.sv
module cdr_lock_guard
   import cdr_lock_pkg::*;
#(
   parameter int unsigned ACC_W     = DEF_ACC_W,
   parameter int unsigned FILT_SHIFT = DEF_SHIFT,
   parameter int unsigned TH_ON     = DEF_TH_ON,
   parameter int unsigned HYST      = DEF_HYST
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             edge_stb_i,
   input  logic             quad_smp_i,
   input  logic             int_sat_hi_i,
   input  logic             int_sat_lo_i,
   input  logic             rt_data_i,
   input  logic             raw_data_i,
   input  logic             reclock_en_i,
   output logic             lock_o,
   output logic             sweep_en_o,
   output logic             sweep_up_o,
   output logic [ACC_W-1:0] jitter_level_o,
   output logic             data_o
);
   localparam int unsigned TH_OFF = TH_ON - HYST;

   if (ACC_W < 4 || ACC_W > 30) begin : g_bad_width
      $error("cdr_lock_guard: ACC_W out of range");
   end
   if (FILT_SHIFT < 1 || FILT_SHIFT > ACC_W - 2) begin : g_bad_shift
      $error("cdr_lock_guard: FILT_SHIFT out of range");
   end
   if (TH_ON >= (1 << ACC_W) || HYST >= TH_ON) begin : g_bad_thresh
      $error("cdr_lock_guard: thresholds inconsistent");
   end

   logic [ACC_W-1:0] level;
   logic             plock;
   logic             data_present;

   qfrac_filter #(.ACC_W(ACC_W), .SHIFT(FILT_SHIFT)) u_filt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .stb_i   (edge_stb_i),
      .smp_i   (quad_smp_i),
      .level_o (level)
   );

   lock_hysteresis #(.ACC_W(ACC_W), .TH_ON(TH_ON), .TH_OFF(TH_OFF)) u_hyst (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (level),
      .plock_o (plock)
   );

   sweep_ctrl u_sweep (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .plock_i    (plock),
      .sat_hi_i   (int_sat_hi_i),
      .sat_lo_i   (int_sat_lo_i),
      .sweep_en_o (sweep_en_o),
      .sweep_up_o (sweep_up_o)
   );

   assign data_present = !(int_sat_hi_i || int_sat_lo_i);
   assign lock_o       = plock && data_present;

   out_gate u_gate (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .lock_i       (lock_o),
      .rt_i         (rt_data_i),
      .raw_i        (raw_data_i),
      .reclock_en_i (reclock_en_i),
      .data_o       (data_o)
   );

   assign jitter_level_o = level;
endmodule

// File: rtl/cdr_lock_guard_chk.sv
module cdr_lock_guard_chk #(
   parameter int unsigned ACC_W = 16,
   parameter int unsigned TH_ON = 43253
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             edge_stb_i,
   input logic             int_sat_hi_i,
   input logic             int_sat_lo_i,
   input logic             raw_data_i,
   input logic             reclock_en_i,
   input logic             lock_o,
   input logic             sweep_en_o,
   input logic             sweep_up_o,
   input logic [ACC_W-1:0] jitter_level_o,
   input logic             data_o
);
   logic armed_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) armed_q <= 1'b0;
      else       armed_q <= 1'b1;
   end

   // R5
   sat_blocks_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (int_sat_hi_i || int_sat_lo_i) |-> !lock_o);

   // R6
   no_sweep_when_locked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      lock_o |-> !sweep_en_o);

   // R10
   bypass_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !reclock_en_i |-> (data_o == raw_data_i));

   // R9
   mute_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      (reclock_en_i && !lock_o) |=> (!reclock_en_i || data_o == $past(data_o)));

   // R7
   rail_reverse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sweep_en_o && int_sat_hi_i) |=> !sweep_up_o);

   // R2
   level_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      !edge_stb_i |=> $stable(jitter_level_o));

   // R3
   lock_needs_level_chk: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
      $fell(sweep_en_o) |-> ($past(jitter_level_o) > ACC_W'(TH_ON)));
endmodule

bind cdr_lock_guard cdr_lock_guard_chk #(.ACC_W(ACC_W), .TH_ON(TH_ON)) u_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .edge_stb_i     (edge_stb_i),
   .int_sat_hi_i   (int_sat_hi_i),
   .int_sat_lo_i   (int_sat_lo_i),
   .raw_data_i     (raw_data_i),
   .reclock_en_i   (reclock_en_i),
   .lock_o         (lock_o),
   .sweep_en_o     (sweep_en_o),
   .sweep_up_o     (sweep_up_o),
   .jitter_level_o (jitter_level_o),
   .data_o         (data_o)
);

// File: tb/test_cdr_lock_guard.sv
`timescale 1ns/100ps
module test_cdr_lock_guard;
   localparam int W     = 16;
   localparam int SH    = 6;
   localparam int T_ON  = 43253;
   localparam int T_OFF = 43253 - 2048;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic stb = 0, qs = 0, shi = 0, slo = 0, rt = 0, raw = 0, ren = 1;
   logic lock, swen, swup, dout;
   logic [W-1:0] lvl;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   int avg_m = 0;
   bit pl_m = 0, up_m = 1, held_m = 0;

   always #2.5 clk = ~clk;

   cdr_lock_guard i_cdr_lock_guard (
      .clk_i(clk), .rst_i(rst), .edge_stb_i(stb), .quad_smp_i(qs),
      .int_sat_hi_i(shi), .int_sat_lo_i(slo), .rt_data_i(rt),
      .raw_data_i(raw), .reclock_en_i(ren), .lock_o(lock),
      .sweep_en_o(swen), .sweep_up_o(swup), .jitter_level_o(lvl),
      .data_o(dout));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive, check outputs against model, advance model at edge
   task automatic cyc(input bit s, input bit q, input bit hi, input bit lo,
                      input bit r, input bit w, input bit en, input bit pl_prev);
      bit lk, pl_n;
      int a_n;
      @(negedge clk);
      stb = s; qs = q; shi = hi; slo = lo; rt = r; raw = w; ren = en;
      #1;
      lk = pl_m && !hi && !lo;
      chk("R5 lock_o", lock, lk);
      if (pl_m && !pl_prev)      chk("R3 phase lock set", swen, 0);
      else if (!pl_m && pl_prev) chk("R4 phase lock clear", swen, 1);
      else                       chk("R6 sweep_en", swen, !pl_m);
      chk("R7 sweep_up", swup, up_m);
      chk("R2 level", lvl, avg_m);
      if (!en)        chk("R10 bypass", dout, w);
      else            chk(pl_prev ? "R8 retimed" : "R9 muted", dout, held_m);
      // model next state
      pl_n = pl_m;
      if (!pl_m && avg_m > T_ON) pl_n = 1;
      else if (pl_m && avg_m < T_OFF) pl_n = 0;
      a_n = avg_m;
      if (s) a_n = q ? avg_m + ((65536 - avg_m) >> SH) : avg_m - (avg_m >> SH);
      if (!pl_m) begin
         if (hi) up_m = 0;
         else if (lo) up_m = 1;
      end
      if (lk) held_m = r;
      @(posedge clk);
      avg_m = a_n;
      pl_m  = pl_n;
   endtask

   task automatic run(input int n, input int pct_hi, input int stb_pct,
                      input int sat_mode, input int byp_pct);
      for (int i = 0; i < n; i++) begin
         bit hi, lo, prev;
         hi = 0; lo = 0;
         if (sat_mode == 1) begin
            hi = (i % 40) == 10;
            lo = (i % 40) == 30;
         end else if (sat_mode == 2) begin
            hi = (i % 25) >= 20 && (i % 50) < 25;
            lo = (i % 25) >= 20 && (i % 50) >= 25;
         end
         prev = pl_m;
         cyc($urandom_range(99) < stb_pct, $urandom_range(99) < pct_hi, hi, lo,
             $urandom_range(1), $urandom_range(1), $urandom_range(99) >= byp_pct, prev);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset values while reset still held
      chk("R1 lock_o", lock, 0);
      chk("R1 sweep_en", swen, 1);
      chk("R1 sweep_up", swup, 1);
      chk("R1 level", lvl, 0);
      chk("R1 data_o", dout, 0);
      rst = 0;
      // unlocked, half-high samples, sweeping across rails
      run(600, 50, 100, 1, 0);
      // clean lock acquisition, sparse edges
      run(800, 100, 60, 0, 0);
      // locked, integrator hits rails: lock drops, mute holds (R5, R9)
      run(300, 100, 100, 2, 0);
      // locked with bypass toggling (R10)
      run(300, 100, 100, 0, 50);
      // moderate jitter: stays inside hysteresis (R4 hold)
      run(600, 72, 100, 0, 0);
      // heavy jitter: loses lock and sweeps again
      run(600, 45, 100, 1, 20);
      // no edges at all: level frozen (R2)
      run(100, 100, 0, 0, 0);
      // reacquire then bypass only
      run(500, 100, 100, 0, 0);
      run(200, 30, 100, 1, 100);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule